// File: doc/BRIEF.md
# H-bridge PWM output controller

This block turns a free-running up-counter and three compare values into a high-side and a low-side drive waveform for a full bridge, and steers them onto one of two output pairs while the other pair is parked. A small control register selects enable, bridge mode, direction, a forced high-side-off pattern, a global invert and whether the compare values are reloaded. The compare values written by software are double-buffered: the working copies are refreshed only as the counter steps from 0 to 1, so a new duty setting never tears a period.

Two side functions share the counter: a convert-start pulse for an ADC, issued a programmable number of clocks after the low-side waveform rises, and a trip path. A synchronous trip input forces every output to its safe state and latches an interrupt flag that stays set until software writes the clear address.

Top module: `hbridge_pwm`

## Requirements
- R1: Control bits are en (bit 0), bridge mode (bit 1), dir (bit 2), load (bit 3), hs_off (bit 4), invert (bit 5); after reset the control value is 0x12, so en is clear and all outputs read 4'hF, conv_start_o and trip_irq_o read 0.
- R2: With en clear, pwm_o is 4'hF whatever the other control bits hold.
- R3: With en set but bridge mode clear, pwm_o is 4'hF.
- R4: With en and bridge mode set and hs_off set, outputs 1 and 3 (pwm_o[0], pwm_o[2]) are high and outputs 2 and 4 (pwm_o[1], pwm_o[3]) are low.
- R5: In normal bridge operation with invert clear, dir=1 puts high-side on pwm_o[0] and low-side on pwm_o[1] with pwm_o[3:2] held 0; dir=0 puts high-side on pwm_o[2] and low-side on pwm_o[3] with pwm_o[1:0] held 0.
- R6: With invert set in normal bridge operation, all four routed values of R5 are inverted, so the parked pair reads high.
- R7: While en is set the counter runs 0,1,..,period and wraps to 0 (held at 0 while en is clear); high-side is high while counter < cmp0, low-side is high while cmp1 <= counter < cmp2.
- R8: Working compare values copy the written ones only on a counter step from 0 to 1 while load is set; otherwise writes to the compare addresses do not change the waveforms.
- R9: conv_start_o pulses for one clock, dly+1 clocks after the low-side waveform (while en is set) rises, only if low-side stays high through that delay; a delay longer than the pulse yields no pulse.
- R10: A high trip_i, registered once, sets trip_irq_o and forces pwm_o to 4'hF until a write of any value to the clear address (6) with trip_i low.
- R11: pwm_o is registered: it reflects the counter and control state of the previous clock. Addresses: 0 control, 1 period, 2..4 cmp0..cmp2, 5 convert delay, 6 interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| trip_i | input | 1 | Trip request, synchronous to clk_i |
| pwm_o | output | 4 | Bridge outputs, bit 0 is output 1 |
| conv_start_o | output | 1 | ADC convert-start pulse |
| trip_irq_o | output | 1 | Latched trip interrupt |

## Verification
The assertions assume trip_i is already synchronous to the clock and that each write lasts a single clock with an address inside the map; the bench drives every input on the falling edge and only issues such writes. Period and compare values may change while the counter runs, so the wrap check only demands a return to zero once the counter meets or passes the period, and the random phase deliberately writes periods below the running count. Compare values are drawn around the period so that empty, full and partly overlapping low-side windows all occur.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;
  localparam int unsigned NCMP = 3;

  typedef struct packed {
    logic inv;
    logic hs_off;
    logic load;
    logic dir;
    logic bridge;
    logic en;
  } ctrl_t;

  localparam logic [5:0] CTRL_RST = 6'h12;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PER  = 3'd1;
  localparam logic [2:0] A_CMP0 = 3'd2;
  localparam logic [2:0] A_DLY  = 3'd5;
  localparam logic [2:0] A_CLR  = 3'd6;
endpackage

// File: rtl/hb_regs.sv
module hb_regs
  import hb_pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [2:0]               addr_i,
  input  logic [CW-1:0]            wdata_i,
  input  logic                     trip_i,
  output ctrl_t                    ctrl_o,
  output logic [CW-1:0]            period_o,
  output logic [NCMP-1:0][CW-1:0]  cmp_o,
  output logic [CW-1:0]            dly_o,
  output logic                     trip_act_o,
  output logic                     irq_o
);
  logic trip_q;
  logic clr_wr;

  assign clr_wr = wr_en_i && (addr_i == A_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= ctrl_t'(CTRL_RST);
      period_o <= '0;
      dly_o    <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) ctrl_o   <= ctrl_t'(wdata_i[5:0]);
      if (addr_i == A_PER)  period_o <= wdata_i;
      if (addr_i == A_DLY)  dly_o    <= wdata_i;
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    localparam logic [2:0] ADDR = A_CMP0 + 3'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        cmp_o[g] <= '0;
      else if (wr_en_i && addr_i == ADDR) cmp_o[g] <= wdata_i;
    end
  end

  // trip sampled once; set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      trip_q <= trip_i;
      if (trip_q)      irq_o <= 1'b1;
      else if (clr_wr) irq_o <= 1'b0;
    end
  end

  assign trip_act_o = trip_q | irq_o;

  p_trip_sets_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_q |=> irq_o);
  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);
endmodule

// File: rtl/hb_timer.sv
module hb_timer
  import hb_pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     load_i,
  input  logic [CW-1:0]            period_i,
  input  logic [NCMP-1:0][CW-1:0]  cmp_usr_i,
  output logic                     hs_o,
  output logic                     ls_o
);
  logic [CW-1:0]           cnt_q;
  logic [NCMP-1:0][CW-1:0] cmp_act;
  logic                    ld_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i)               cnt_q <= '0;
    else if (cnt_q >= period_i)   cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // reload exactly when the counter is about to go 0 -> 1
  assign ld_evt = en_i && load_i && (cnt_q == '0) && (period_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_act <= '0;
    else if (ld_evt) cmp_act <= cmp_usr_i;
  end

  assign hs_o = cnt_q < cmp_act[0];
  assign ls_o = (cnt_q >= cmp_act[1]) && (cnt_q < cmp_act[2]);

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q >= period_i) |=> (cnt_q == '0));
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (cnt_q == '0));
  p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_evt) |=> $stable(cmp_act));
endmodule

// File: rtl/hb_route.sv
module hb_route (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       bridge_i,
  input  logic       dir_i,
  input  logic       hs_off_i,
  input  logic       inv_i,
  input  logic       trip_act_i,
  input  logic       hs_i,
  input  logic       ls_i,
  output logic [3:0] pwm_o
);
  logic [3:0] routed;
  logic [3:0] pwm_d;
  logic       safe;
  logic       normal;

  assign safe   = trip_act_i || !en_i || !bridge_i;
  assign normal = !safe && !hs_off_i;
  assign routed = dir_i ? {2'b00, ls_i, hs_i} : {ls_i, hs_i, 2'b00};

  always_comb begin
    if (safe)          pwm_d = 4'hF;
    else if (hs_off_i) pwm_d = 4'b0101;
    else               pwm_d = inv_i ? ~routed : routed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_o <= 4'hF;
    else         pwm_o <= pwm_d;
  end

  p_off_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (pwm_o == 4'hF));
  p_trip_safe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_act_i |=> (pwm_o == 4'hF));
  p_hs_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!safe && hs_off_i) |=> (pwm_o == 4'b0101));
  p_park_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (normal && !inv_i) |=> ($past(dir_i) ? (pwm_o[3:2] == 2'b00) : (pwm_o[1:0] == 2'b00)));
  p_park_inv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (normal && inv_i) |=> ($past(dir_i) ? (pwm_o[3:2] == 2'b11) : (pwm_o[1:0] == 2'b11)));
endmodule

// File: rtl/hb_adc_trig.sv
module hb_adc_trig #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ls_i,
  input  logic [CW-1:0] dly_i,
  output logic          conv_o
);
  logic          ls_q;
  logic          armed;
  logic [CW-1:0] elapsed;
  logic          rise;

  assign rise = ls_i && !ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_q    <= 1'b0;
      armed   <= 1'b0;
      elapsed <= '0;
      conv_o  <= 1'b0;
    end else begin
      ls_q   <= ls_i;
      conv_o <= 1'b0;
      if (rise) begin
        if (dly_i == '0) begin
          conv_o <= 1'b1;
          armed  <= 1'b0;
        end else begin
          armed   <= 1'b1;
          elapsed <= CW'(1);
        end
      end else if (armed) begin
        if (!ls_i) begin
          armed <= 1'b0;
        end else if (elapsed == dly_i) begin
          conv_o <= 1'b1;
          armed  <= 1'b0;
        end else begin
          elapsed <= elapsed + 1'b1;
        end
      end
    end
  end

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);
  p_pulse_in_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> $past(ls_i));
endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm
  import hb_pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          trip_i,
  output logic [3:0]    pwm_o,
  output logic          conv_start_o,
  output logic          trip_irq_o
);
  ctrl_t                   ctrl;
  logic [CW-1:0]           period;
  logic [CW-1:0]           dly;
  logic [NCMP-1:0][CW-1:0] cmp_usr;
  logic                    trip_act;
  logic                    hs;
  logic                    ls;

  hb_regs #(.CW(CW)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .trip_i,
    .ctrl_o(ctrl), .period_o(period), .cmp_o(cmp_usr), .dly_o(dly),
    .trip_act_o(trip_act), .irq_o(trip_irq_o)
  );

  hb_timer #(.CW(CW)) i_timer (
    .clk_i, .rst_ni, .en_i(ctrl.en), .load_i(ctrl.load),
    .period_i(period), .cmp_usr_i(cmp_usr), .hs_o(hs), .ls_o(ls)
  );

  hb_route i_route (
    .clk_i, .rst_ni, .en_i(ctrl.en), .bridge_i(ctrl.bridge), .dir_i(ctrl.dir),
    .hs_off_i(ctrl.hs_off), .inv_i(ctrl.inv), .trip_act_i(trip_act),
    .hs_i(hs), .ls_i(ls), .pwm_o
  );

  hb_adc_trig #(.CW(CW)) i_adc_trig (
    .clk_i, .rst_ni, .ls_i(ls && ctrl.en), .dly_i(dly), .conv_o(conv_start_o)
  );
endmodule

// File: tb/test_hbridge_pwm.sv
module test_hbridge_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        trip = 1'b0;
  logic [3:0]  pwm;
  logic        conv;
  logic        irq;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  string       tag = "R1";
  int unsigned conv_seen = 0;

  // reference state, built from the requirements
  logic [5:0]  m_ctrl;
  logic [15:0] m_per, m_dly, m_cnt;
  logic [15:0] m_usr [3];
  logic [15:0] m_act [3];
  logic        m_trq, m_irq, m_lsq, m_armed, m_conv;
  logic [15:0] m_el;
  logic [3:0]  m_pwm;

  always #10 clk = ~clk;

  hbridge_pwm i_hbridge_pwm (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .trip_i(trip), .pwm_o(pwm), .conv_start_o(conv), .trip_irq_o(irq)
  );

  function automatic logic [3:0] exp_pwm(logic [5:0] c, logic ta, logic hs, logic ls);
    logic [3:0] r;
    if (ta || !c[0] || !c[1]) return 4'hF;   // R2 R3 R10
    if (c[4]) return 4'b0101;                 // R4
    r = c[2] ? {2'b00, ls, hs} : {ls, hs, 2'b00}; // R5
    return c[5] ? ~r : r;                     // R6
  endfunction

  task automatic model_reset();
    m_ctrl = 6'h12; m_per = 0; m_dly = 0; m_cnt = 0;
    for (int i = 0; i < 3; i++) begin m_usr[i] = 0; m_act[i] = 0; end
    m_trq = 0; m_irq = 0; m_lsq = 0; m_armed = 0; m_conv = 0; m_el = 0; m_pwm = 4'hF;
  endtask

  task automatic model_step();
    logic hs, ls, lsa, rise, n_armed, n_conv, n_irq;
    logic [15:0] n_el, n_cnt;
    hs  = m_cnt < m_act[0];
    ls  = (m_cnt >= m_act[1]) && (m_cnt < m_act[2]);
    lsa = ls && m_ctrl[0];
    rise = lsa && !m_lsq;
    n_conv = 0; n_armed = m_armed; n_el = m_el;
    if (rise) begin
      if (m_dly == 0) begin n_conv = 1; n_armed = 0; end
      else begin n_armed = 1; n_el = 1; end
    end else if (m_armed) begin
      if (!lsa) n_armed = 0;
      else if (m_el == m_dly) begin n_conv = 1; n_armed = 0; end
      else n_el = m_el + 1;
    end
    if (!m_ctrl[0]) n_cnt = 0;
    else if (m_cnt >= m_per) n_cnt = 0;
    else n_cnt = m_cnt + 1;
    if (m_ctrl[0] && m_ctrl[3] && m_cnt == 0 && m_per != 0)
      for (int i = 0; i < 3; i++) m_act[i] = m_usr[i];
    n_irq = m_irq;
    if (m_trq) n_irq = 1;
    else if (wr_en && addr == 3'd6) n_irq = 0;
    m_pwm = exp_pwm(m_ctrl, m_irq | m_trq, hs, ls);
    m_conv = n_conv; m_armed = n_armed; m_el = n_el; m_lsq = lsa;
    m_cnt = n_cnt; m_irq = n_irq; m_trq = trip;
    if (wr_en) begin
      case (addr)
        3'd0: m_ctrl = wdata[5:0];
        3'd1: m_per = wdata;
        3'd2: m_usr[0] = wdata;
        3'd3: m_usr[1] = wdata;
        3'd4: m_usr[2] = wdata;
        3'd5: m_dly = wdata;
        default: ;
      endcase
    end
  endtask

  task automatic check(string t, logic [3:0] p_exp, logic c_exp, logic i_exp);
    n_chk++;
    // R11: pwm compared after the edge that registered it
    if (pwm !== p_exp) begin
      n_bad++;
      $display("FAIL %s pwm_o act=%b exp=%b", t, pwm, p_exp);
    end
    if (conv !== c_exp) begin
      n_bad++;
      $display("FAIL R9 (%s) conv_start_o act=%b exp=%b", t, conv, c_exp);
    end
    if (irq !== i_exp) begin
      n_bad++;
      $display("FAIL R10 (%s) trip_irq_o act=%b exp=%b", t, irq, i_exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (conv) conv_seen++;
    check(tag, m_pwm, m_conv, m_irq);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    cycle();
    wr_en = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    check("R1", 4'hF, 1'b0, 1'b0);
    run(4);

    // waveform setup: period 9, hs while <4, ls for 2..7
    tag = "R2";
    wr(3'd1, 16'd9); wr(3'd2, 16'd4); wr(3'd3, 16'd2); wr(3'd4, 16'd7);
    wr(3'd0, 16'h3E);  // everything but en
    run(12);
    tag = "R3";
    wr(3'd0, 16'h09);  // en + load, bridge clear
    run(15);
    tag = "R4";
    wr(3'd0, 16'h1B);
    run(12);
    tag = "R5";
    wr(3'd0, 16'h0F);  // dir=1
    run(25);
    wr(3'd0, 16'h0B);  // dir=0
    run(25);
    tag = "R6";
    wr(3'd0, 16'h2F);
    run(22);
    wr(3'd0, 16'h2B);
    run(22);
    tag = "R7";
    wr(3'd1, 16'd3);
    run(12);
    wr(3'd1, 16'd0);
    run(5);
    wr(3'd1, 16'd11);
    run(24);

    // R8: load clear freezes the working compares
    tag = "R8";
    wr(3'd0, 16'h07);
    wr(3'd2, 16'd0); wr(3'd3, 16'd0); wr(3'd4, 16'd0);
    run(30);
    wr(3'd0, 16'h0F);
    run(30);

    // R9: delay inside and beyond the low-side pulse
    tag = "R9";
    wr(3'd3, 16'd2); wr(3'd4, 16'd8); wr(3'd5, 16'd3);
    conv_seen = 0;
    run(40);
    n_chk++;
    if (conv_seen == 0) begin
      n_bad++;
      $display("FAIL R9 pulses act=%0d exp=>0", conv_seen);
    end
    wr(3'd5, 16'd0);
    run(20);
    wr(3'd5, 16'd9);   // pulse is 6 clocks wide
    run(4);
    conv_seen = 0;
    run(40);
    n_chk++;
    if (conv_seen != 0) begin
      n_bad++;
      $display("FAIL R9 long-delay pulses act=%0d exp=0", conv_seen);
    end

    // R10: trip, hold, clear
    tag = "R10";
    trip = 1; cycle(); trip = 0;
    run(15);
    wr(3'd6, 16'h1234);
    run(12);
    trip = 1; run(3);
    wr(3'd6, 16'h0);   // clear ignored while trip_i high
    trip = 0;
    run(4);
    wr(3'd6, 16'h0);
    run(8);

    // R11: random mix, every cycle compared
    tag = "R11";
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      if (r < 4) begin
        logic [5:0] c;
        c = 6'($urandom);
        if ($urandom_range(0, 9) < 8) c[0] = 1;
        if ($urandom_range(0, 9) < 8) c[1] = 1;
        if ($urandom_range(0, 9) < 7) c[4] = 0;
        wr(3'd0, {10'd0, c});
      end else if (r < 6) wr(3'd1, 16'($urandom_range(0, 20)));
      else if (r < 12) wr(3'($urandom_range(2, 4)), 16'($urandom_range(0, 22)));
      else if (r < 14) wr(3'd5, 16'($urandom_range(0, 7)));
      else if (r < 15) begin trip = 1; cycle(); trip = 0; end
      else if (r < 18) wr(3'd6, 16'($urandom));
      else cycle();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule